// File: doc/BRIEF.md
# Segment Descriptor Cache and Privilege Check

This block keeps the state of a small set of segment registers. Each register has two parts. The visible part is a 16-bit selector. The hidden part is a cache that holds a linear base, a byte limit and a privilege level. Software fills a small descriptor table inside the block through a write port. It then asks for a selector to be loaded into one register. A three-state controller fetches the table entry and judges the request. It then either rewrites that register's hidden cache or reports a protection fault. A faulted load changes nothing.

Data accesses name a register and an offset. They use only the hidden cache. An offset above the cached limit faults. Any other offset yields base plus offset one cycle later. The block has two modes, real-style and protected. Switching between them never touches the caches, so translations made under one mode stay in force until each register is loaded again.

The load controller has three states. LD_IDLE waits for work and takes the transition "accept" to LD_FETCH when a load request is present. LD_FETCH reads the table and always takes the transition "lookup" to LD_CHECK. LD_CHECK judges the request, pulses the done flag and always takes the transition "retire" back to LD_IDLE.

Top module: `segcache_unit`

## Requirements
- R1: After reset every register holds selector 0, base 0, limit 0xFFFF and privilege level 0. The controller is in LD_IDLE, and every output reads 0.
- R2: A load request is accepted only in LD_IDLE. `ld_busy_o` is high for the two cycles after acceptance. `ld_done_o` is high only in the second of them. A request made while busy is ignored.
- R3: In real-style mode (`prot_mode_i` = 0) a load never faults. It sets base = selector × 16, limit = 0xFFFF and privilege level 0, whatever the current level or the selector bits.
- R4: In protected mode the selector is decoded as follows. Bits [15:3] are the table index, bit 2 is the table indicator and bits [1:0] are the requestor level. A selector with bit 2 set faults.
- R5: In protected mode an index at or above DEPTH faults. Index DEPTH-1 is accepted.
- R6: In protected mode, take the numerically larger of the current level `cpl_i` and the requestor level. The load faults when that value is greater than the entry's privilege level, and is allowed when it is equal or smaller.
- R7: A successful protected load copies the entry's base, limit and level into the named register, and stores the selector. A faulted load leaves the selector and cache of every register unchanged.
- R8: A change of `prot_mode_i` alters no cache. Accesses keep the previous translation until the register is reloaded.
- R9: An access sampled at one clock edge reports `acc_done_o` after that edge, together with the register's selector on `acc_sel_o`. It faults with linear address 0 when the offset exceeds the cached limit. Otherwise the address is base + offset, modulo 2^ADDR_W. When no access is presented, all access outputs are 0.
- R10: A table write stores base, limit and level at `tbl_idx_i`. Loads accepted afterwards see the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real-style mode |
| cpl_i | input | 2 | Current privilege level |
| ld_valid_i | input | 1 | Selector load request |
| ld_seg_i | input | SEG_W | Register to load |
| ld_sel_i | input | 16 | Selector to load |
| ld_busy_o | output | 1 | Load in progress |
| ld_done_o | output | 1 | Load judged this cycle |
| ld_fault_o | output | 1 | Load faulted (with done) |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | IDX_W | Table entry to write |
| tbl_base_i | input | ADDR_W | Entry base |
| tbl_limit_i | input | ADDR_W | Entry limit |
| tbl_dpl_i | input | 2 | Entry privilege level |
| acc_valid_i | input | 1 | Data access request |
| acc_seg_i | input | SEG_W | Register used by the access |
| acc_off_i | input | ADDR_W | Access offset |
| acc_done_o | output | 1 | Access result valid |
| acc_fault_o | output | 1 | Access exceeded the limit |
| acc_lin_o | output | ADDR_W | Linear address |
| acc_sel_o | output | 16 | Visible selector of the accessed register |

## Verification
The assertions assume several things about the inputs. A load's mode input is the one present at its acceptance edge. Loads are only judged after LD_FETCH has run. No access register index goes past the last register. The stimulus always drives a register index below NSEG. It writes the table only while no load is in flight, so the entry fetched matches the entry present at acceptance. It changes mode and level only on falling edges, so every request sees a settled value.

// File: rtl/segcache_pkg.sv
package segcache_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_CHECK = 2'd2
    } ld_state_e;

    localparam int SEL_W       = 16;
    localparam int SEL_TI_BIT  = 2;
    localparam int SEL_IDX_LSB = 3;
    localparam int SEL_IDX_W   = SEL_W - SEL_IDX_LSB;
    localparam int REAL_SHIFT  = 4;
    localparam logic [31:0] REAL_LIMIT = 32'h0000_FFFF;

    function automatic logic [1:0] pl_max(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/segcache_table.sv
module segcache_table
    import segcache_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_base_i,
    input  logic [ADDR_W-1:0] wr_limit_i,
    input  logic [1:0]        wr_dpl_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_base_o,
    output logic [ADDR_W-1:0] rd_limit_o,
    output logic [1:0]        rd_dpl_o
);

    logic [ADDR_W-1:0] base_mem  [DEPTH];
    logic [ADDR_W-1:0] limit_mem [DEPTH];
    logic [1:0]        dpl_mem   [DEPTH];

    // R10: one entry written per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                base_mem[i]  <= '0;
                limit_mem[i] <= '0;
                dpl_mem[i]   <= '0;
            end
        end else if (wr_en_i && (int'(wr_idx_i) < DEPTH)) begin
            base_mem[wr_idx_i]  <= wr_base_i;
            limit_mem[wr_idx_i] <= wr_limit_i;
            dpl_mem[wr_idx_i]   <= wr_dpl_i;
        end
    end

    // registered read, valid the cycle after rd_en_i
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_base_o  <= '0;
            rd_limit_o <= '0;
            rd_dpl_o   <= '0;
        end else if (rd_en_i) begin
            if (int'(rd_idx_i) < DEPTH) begin
                rd_base_o  <= base_mem[rd_idx_i];
                rd_limit_o <= limit_mem[rd_idx_i];
                rd_dpl_o   <= dpl_mem[rd_idx_i];
            end else begin
                rd_base_o  <= '0;
                rd_limit_o <= '0;
                rd_dpl_o   <= '0;
            end
        end
    end

endmodule

// File: rtl/segcache_ctrl.sv
module segcache_ctrl
    import segcache_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int DEPTH = 8,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_mode_i,
    input  logic [1:0]       cpl_i,
    input  logic             ld_valid_i,
    input  logic [SEG_W-1:0] ld_seg_i,
    input  logic [SEL_W-1:0] ld_sel_i,
    input  logic [1:0]       tbl_dpl_i,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             commit_en_o,
    output logic             commit_real_o,
    output logic [SEG_W-1:0] commit_seg_o,
    output logic [SEL_W-1:0] commit_sel_o,
    output logic [1:0]       commit_pl_o,
    output logic             ld_busy_o,
    output logic             ld_done_o,
    output logic             ld_fault_o
);

    ld_state_e state_q, state_d;

    logic             prot_q;
    logic [1:0]       cpl_q;
    logic [SEG_W-1:0] seg_q;
    logic [SEL_W-1:0] sel_q;

    logic [SEL_IDX_W-1:0] idx_f;
    logic                 ti_f;
    logic [1:0]           rpl_f;
    logic [1:0]           eff_pl;
    logic                 idx_oob;
    logic                 deny;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // request capture on the accept transition (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            cpl_q  <= '0;
            seg_q  <= '0;
            sel_q  <= '0;
        end else if (state_q == LD_IDLE && ld_valid_i) begin
            prot_q <= prot_mode_i;
            cpl_q  <= cpl_i;
            seg_q  <= ld_seg_i;
            sel_q  <= ld_sel_i;
        end
    end

    // transitions: accept, lookup, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (ld_valid_i) state_d = LD_FETCH;
            LD_FETCH: state_d = LD_CHECK;
            LD_CHECK: state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // selector field decode (R4) and judgement (R5, R6)
    always_comb begin
        idx_f   = sel_q[SEL_W-1:SEL_IDX_LSB];
        ti_f    = sel_q[SEL_TI_BIT];
        rpl_f   = sel_q[1:0];
        eff_pl  = pl_max(cpl_q, rpl_f);
        idx_oob = (int'(idx_f) >= DEPTH);
        deny    = prot_q && (ti_f || idx_oob || (eff_pl > tbl_dpl_i));
    end

    // outputs
    always_comb begin
        rd_en_o     = 1'b0;
        commit_en_o = 1'b0;
        ld_busy_o   = 1'b0;
        ld_done_o   = 1'b0;
        ld_fault_o  = 1'b0;
        unique case (state_q)
            LD_IDLE: ;
            LD_FETCH: begin
                ld_busy_o = 1'b1;
                rd_en_o   = 1'b1;
            end
            LD_CHECK: begin
                ld_busy_o   = 1'b1;
                ld_done_o   = 1'b1;
                ld_fault_o  = deny;
                commit_en_o = !deny;
            end
            default: ;
        endcase
    end

    assign rd_idx_o      = sel_q[SEL_IDX_LSB +: IDX_W];
    assign commit_real_o = !prot_q;
    assign commit_seg_o  = seg_q;
    assign commit_sel_o  = sel_q;
    assign commit_pl_o   = eff_pl;

endmodule

// File: rtl/segcache_regs.sv
module segcache_regs
    import segcache_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 32,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_en_i,
    input  logic                         commit_real_i,
    input  logic [SEG_W-1:0]             commit_seg_i,
    input  logic [SEL_W-1:0]             commit_sel_i,
    input  logic [ADDR_W-1:0]            tbl_base_i,
    input  logic [ADDR_W-1:0]            tbl_limit_i,
    input  logic [1:0]                   tbl_dpl_i,
    output logic [NSEG-1:0][SEL_W-1:0]   c_sel_o,
    output logic [NSEG-1:0][ADDR_W-1:0]  c_base_o,
    output logic [NSEG-1:0][ADDR_W-1:0]  c_limit_o,
    output logic [NSEG-1:0][1:0]         c_dpl_o
);

    logic [ADDR_W-1:0] new_base;
    logic [ADDR_W-1:0] new_limit;
    logic [1:0]        new_dpl;

    // R3 real-style image, R7 table image
    always_comb begin
        if (commit_real_i) begin
            new_base  = ADDR_W'({commit_sel_i, {REAL_SHIFT{1'b0}}});
            new_limit = ADDR_W'(REAL_LIMIT);
            new_dpl   = 2'd0;
        end else begin
            new_base  = tbl_base_i;
            new_limit = tbl_limit_i;
            new_dpl   = tbl_dpl_i;
        end
    end

    // R8: only a commit rewrites a register
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_sel_o[g]   <= '0;
                c_base_o[g]  <= '0;
                c_limit_o[g] <= ADDR_W'(REAL_LIMIT);
                c_dpl_o[g]   <= '0;
            end else if (commit_en_i && (commit_seg_i == SEG_W'(g))) begin
                c_sel_o[g]   <= commit_sel_i;
                c_base_o[g]  <= new_base;
                c_limit_o[g] <= new_limit;
                c_dpl_o[g]   <= new_dpl;
            end
        end
    end

endmodule

// File: rtl/segcache_xlate.sv
module segcache_xlate
    import segcache_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 32,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid_i,
    input  logic [SEG_W-1:0]             acc_seg_i,
    input  logic [ADDR_W-1:0]            acc_off_i,
    input  logic [NSEG-1:0][SEL_W-1:0]   c_sel_i,
    input  logic [NSEG-1:0][ADDR_W-1:0]  c_base_i,
    input  logic [NSEG-1:0][ADDR_W-1:0]  c_limit_i,
    output logic                         acc_done_o,
    output logic                         acc_fault_o,
    output logic [ADDR_W-1:0]            acc_lin_o,
    output logic [SEL_W-1:0]             acc_sel_o
);

    logic [SEL_W-1:0]  pick_sel;
    logic [ADDR_W-1:0] pick_base;
    logic [ADDR_W-1:0] pick_limit;
    logic              over;

    always_comb begin
        pick_sel   = c_sel_i[acc_seg_i];
        pick_base  = c_base_i[acc_seg_i];
        pick_limit = c_limit_i[acc_seg_i];
        over       = acc_off_i > pick_limit;
    end

    // R9: one-cycle translation from the cached image only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_done_o  <= 1'b0;
            acc_fault_o <= 1'b0;
            acc_lin_o   <= '0;
            acc_sel_o   <= '0;
        end else begin
            acc_done_o  <= acc_valid_i;
            acc_fault_o <= acc_valid_i && over;
            acc_lin_o   <= (acc_valid_i && !over) ? (pick_base + acc_off_i) : '0;
            acc_sel_o   <= acc_valid_i ? pick_sel : '0;
        end
    end

endmodule

// File: rtl/segcache_unit.sv
module segcache_unit
    import segcache_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode_i,
    input  logic [1:0]        cpl_i,
    input  logic              ld_valid_i,
    input  logic [SEG_W-1:0]  ld_seg_i,
    input  logic [15:0]       ld_sel_i,
    output logic              ld_busy_o,
    output logic              ld_done_o,
    output logic              ld_fault_o,
    input  logic              tbl_we_i,
    input  logic [IDX_W-1:0]  tbl_idx_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [ADDR_W-1:0] tbl_limit_i,
    input  logic [1:0]        tbl_dpl_i,
    input  logic              acc_valid_i,
    input  logic [SEG_W-1:0]  acc_seg_i,
    input  logic [ADDR_W-1:0] acc_off_i,
    output logic              acc_done_o,
    output logic              acc_fault_o,
    output logic [ADDR_W-1:0] acc_lin_o,
    output logic [15:0]       acc_sel_o
);

    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] rd_base;
    logic [ADDR_W-1:0] rd_limit;
    logic [1:0]        rd_dpl;

    logic              commit_en;
    logic              commit_real;
    logic [SEG_W-1:0]  commit_seg;
    logic [SEL_W-1:0]  commit_sel;
    logic [1:0]        commit_pl;

    logic [NSEG-1:0][SEL_W-1:0]  c_sel;
    logic [NSEG-1:0][ADDR_W-1:0] c_base;
    logic [NSEG-1:0][ADDR_W-1:0] c_limit;
    logic [NSEG-1:0][1:0]        c_dpl;

    segcache_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (tbl_we_i),
        .wr_idx_i   (tbl_idx_i),
        .wr_base_i  (tbl_base_i),
        .wr_limit_i (tbl_limit_i),
        .wr_dpl_i   (tbl_dpl_i),
        .rd_en_i    (rd_en),
        .rd_idx_i   (rd_idx),
        .rd_base_o  (rd_base),
        .rd_limit_o (rd_limit),
        .rd_dpl_o   (rd_dpl)
    );

    segcache_ctrl #(.NSEG(NSEG), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prot_mode_i   (prot_mode_i),
        .cpl_i         (cpl_i),
        .ld_valid_i    (ld_valid_i),
        .ld_seg_i      (ld_seg_i),
        .ld_sel_i      (ld_sel_i),
        .tbl_dpl_i     (rd_dpl),
        .rd_en_o       (rd_en),
        .rd_idx_o      (rd_idx),
        .commit_en_o   (commit_en),
        .commit_real_o (commit_real),
        .commit_seg_o  (commit_seg),
        .commit_sel_o  (commit_sel),
        .commit_pl_o   (commit_pl),
        .ld_busy_o     (ld_busy_o),
        .ld_done_o     (ld_done_o),
        .ld_fault_o    (ld_fault_o)
    );

    segcache_regs #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en_i   (commit_en),
        .commit_real_i (commit_real),
        .commit_seg_i  (commit_seg),
        .commit_sel_i  (commit_sel),
        .tbl_base_i    (rd_base),
        .tbl_limit_i   (rd_limit),
        .tbl_dpl_i     (rd_dpl),
        .c_sel_o       (c_sel),
        .c_base_o      (c_base),
        .c_limit_o     (c_limit),
        .c_dpl_o       (c_dpl)
    );

    segcache_xlate #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid_i),
        .acc_seg_i   (acc_seg_i),
        .acc_off_i   (acc_off_i),
        .c_sel_i     (c_sel),
        .c_base_i    (c_base),
        .c_limit_i   (c_limit),
        .acc_done_o  (acc_done_o),
        .acc_fault_o (acc_fault_o),
        .acc_lin_o   (acc_lin_o),
        .acc_sel_o   (acc_sel_o)
    );

endmodule

// File: rtl/segcache_unit_chk.sv
module segcache_unit_chk #(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 32,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        prot_mode_i,
    input logic                        ld_valid_i,
    input logic                        ld_busy_o,
    input logic                        ld_done_o,
    input logic                        ld_fault_o,
    input logic                        acc_valid_i,
    input logic [SEG_W-1:0]            acc_seg_i,
    input logic [ADDR_W-1:0]           acc_off_i,
    input logic                        acc_done_o,
    input logic                        acc_fault_o,
    input logic [ADDR_W-1:0]           acc_lin_o,
    input logic [NSEG-1:0][15:0]       c_sel,
    input logic [NSEG-1:0][ADDR_W-1:0] c_base,
    input logic [NSEG-1:0][ADDR_W-1:0] c_limit,
    input logic [NSEG-1:0][1:0]        c_dpl,
    input logic                        commit_en,
    input logic                        commit_real,
    input logic [SEG_W-1:0]            commit_seg,
    input logic [1:0]                  commit_pl
);

    p_accept_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_busy_o && ld_valid_i) |=> (ld_busy_o && !ld_done_o));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done_o |=> !ld_done_o);

    p_real_never_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done_o && !$past(prot_mode_i, 2)) |-> !ld_fault_o);

    p_dpl_covers_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !commit_real) |=> (c_dpl[$past(commit_seg)] >= $past(commit_pl)));

    p_fault_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault_o |=> ((c_sel == $past(c_sel)) && (c_base == $past(c_base)) &&
                        (c_limit == $past(c_limit)) && (c_dpl == $past(c_dpl))));

    p_only_load_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_done_o |=> ($stable(c_sel) && $stable(c_base) && $stable(c_limit) && $stable(c_dpl)));

    p_limit_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && (acc_off_i > c_limit[acc_seg_i])) |=> (acc_done_o && acc_fault_o));

    p_linear_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !(acc_off_i > c_limit[acc_seg_i])) |=>
        (acc_done_o && !acc_fault_o && (acc_lin_o == $past(c_base[acc_seg_i] + acc_off_i))));

endmodule

bind segcache_unit segcache_unit_chk #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prot_mode_i (prot_mode_i),
    .ld_valid_i  (ld_valid_i),
    .ld_busy_o   (ld_busy_o),
    .ld_done_o   (ld_done_o),
    .ld_fault_o  (ld_fault_o),
    .acc_valid_i (acc_valid_i),
    .acc_seg_i   (acc_seg_i),
    .acc_off_i   (acc_off_i),
    .acc_done_o  (acc_done_o),
    .acc_fault_o (acc_fault_o),
    .acc_lin_o   (acc_lin_o),
    .c_sel       (c_sel),
    .c_base      (c_base),
    .c_limit     (c_limit),
    .c_dpl       (c_dpl),
    .commit_en   (commit_en),
    .commit_real (commit_real),
    .commit_seg  (commit_seg),
    .commit_pl   (commit_pl)
);

// File: tb/segcache_unit_bench.sv
module segcache_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG   = 4;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode_i = 1'b0;
    logic [1:0]  cpl_i = '0;
    logic        ld_valid_i = 1'b0;
    logic [1:0]  ld_seg_i = '0;
    logic [15:0] ld_sel_i = '0;
    logic        ld_busy_o, ld_done_o, ld_fault_o;
    logic        tbl_we_i = 1'b0;
    logic [2:0]  tbl_idx_i = '0;
    logic [31:0] tbl_base_i = '0;
    logic [31:0] tbl_limit_i = '0;
    logic [1:0]  tbl_dpl_i = '0;
    logic        acc_valid_i = 1'b0;
    logic [1:0]  acc_seg_i = '0;
    logic [31:0] acc_off_i = '0;
    logic        acc_done_o, acc_fault_o;
    logic [31:0] acc_lin_o;
    logic [15:0] acc_sel_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    running = 1'b0;

    segcache_unit #(.NSEG(NSEG), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_segcache_unit (
        .clk(clk), .rst_n(rst_n), .prot_mode_i(prot_mode_i), .cpl_i(cpl_i),
        .ld_valid_i(ld_valid_i), .ld_seg_i(ld_seg_i), .ld_sel_i(ld_sel_i),
        .ld_busy_o(ld_busy_o), .ld_done_o(ld_done_o), .ld_fault_o(ld_fault_o),
        .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_base_i(tbl_base_i),
        .tbl_limit_i(tbl_limit_i), .tbl_dpl_i(tbl_dpl_i),
        .acc_valid_i(acc_valid_i), .acc_seg_i(acc_seg_i), .acc_off_i(acc_off_i),
        .acc_done_o(acc_done_o), .acc_fault_o(acc_fault_o),
        .acc_lin_o(acc_lin_o), .acc_sel_o(acc_sel_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    logic [15:0] m_sel [NSEG];
    logic [31:0] m_base [NSEG];
    logic [31:0] m_lim [NSEG];
    logic [31:0] t_base [DEPTH];
    logic [31:0] t_lim [DEPTH];
    logic [1:0]  t_dpl [DEPTH];
    int          m_st;
    bit          p_fault;
    int          p_seg;
    logic [15:0] p_sel;
    logic [31:0] p_base, p_lim;
    bit          e_adone, e_afault;
    logic [31:0] e_alin;
    logic [15:0] e_asel;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 32'hFFFF;
            end
            for (int i = 0; i < DEPTH; i++) begin
                t_base[i] = 0; t_lim[i] = 0; t_dpl[i] = 0;
            end
            m_st = 0; p_fault = 0;
            e_adone = 0; e_afault = 0; e_alin = 0; e_asel = 0;
        end else begin
            e_adone = acc_valid_i; e_afault = 0; e_alin = 0; e_asel = 0;
            if (acc_valid_i) begin
                e_asel = m_sel[acc_seg_i];
                if (acc_off_i > m_lim[acc_seg_i]) e_afault = 1;
                else e_alin = m_base[acc_seg_i] + acc_off_i;
            end
            if (m_st == 2) begin
                if (!p_fault) begin
                    m_sel[p_seg] = p_sel; m_base[p_seg] = p_base; m_lim[p_seg] = p_lim;
                end
                m_st = 0;
            end else if (m_st == 1) begin
                m_st = 2;
            end else if (ld_valid_i) begin
                int idx, rpl, lvl;
                m_st = 1;
                p_seg = int'(ld_seg_i);
                p_sel = ld_sel_i;
                idx = int'(ld_sel_i >> 3);
                rpl = int'(ld_sel_i[1:0]);
                lvl = (rpl > int'(cpl_i)) ? rpl : int'(cpl_i);
                if (!prot_mode_i) begin
                    p_fault = 0; p_base = {12'h0, ld_sel_i, 4'h0}; p_lim = 32'hFFFF;
                end else if (ld_sel_i[2] || idx >= DEPTH) begin
                    p_fault = 1;
                end else begin
                    p_fault = lvl > int'(t_dpl[idx]);
                    p_base = t_base[idx]; p_lim = t_lim[idx];
                end
            end
            if (tbl_we_i) begin
                t_base[tbl_idx_i] = tbl_base_i;
                t_lim[tbl_idx_i] = tbl_limit_i;
                t_dpl[tbl_idx_i] = tbl_dpl_i;
            end
        end
    end

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            cmp("ld_busy", 32'(ld_busy_o), 32'(m_st != 0));
            cmp("ld_done", 32'(ld_done_o), 32'(m_st == 2));
            cmp("ld_fault", 32'(ld_fault_o), 32'(m_st == 2 && p_fault));
            cmp("acc_done", 32'(acc_done_o), 32'(e_adone));
            cmp("acc_fault", 32'(acc_fault_o), 32'(e_afault));
            cmp("acc_lin", acc_lin_o, e_alin);
            cmp("acc_sel", 32'(acc_sel_o), 32'(e_asel));
        end
    end

    task automatic twrite(int idx, logic [31:0] b, logic [31:0] l, logic [1:0] d);
        tbl_we_i = 1; tbl_idx_i = 3'(idx); tbl_base_i = b; tbl_limit_i = l; tbl_dpl_i = d;
        @(negedge clk);
        tbl_we_i = 0;
    endtask

    task automatic load(int seg, logic [15:0] sel);
        ld_valid_i = 1; ld_seg_i = 2'(seg); ld_sel_i = sel;
        @(negedge clk);
        ld_valid_i = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic access(int seg, logic [31:0] off);
        acc_valid_i = 1; acc_seg_i = 2'(seg); acc_off_i = off;
        @(negedge clk);
        acc_valid_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        // R1: reset image seen through the access port
        tag = "R1";
        @(negedge clk);
        for (int s = 0; s < NSEG; s++) begin
            access(s, 32'h0); access(s, 32'hFFFF); access(s, 32'h1_0000);
        end
        // R10: fill the table
        tag = "R10";
        twrite(0, 32'h1000_0000, 32'h0FFF, 2'd0);
        twrite(1, 32'h0002_0000, 32'hFFFF_FFFF, 2'd3);
        twrite(2, 32'h0004_0000, 32'h0100, 2'd1);
        twrite(3, 32'h0300_0000, 32'h3FFF, 2'd2);
        for (int i = 4; i < 7; i++) twrite(i, 32'(i) << 24, 32'h1F, 2'd3);
        twrite(7, 32'h7000_0000, 32'h07FF, 2'd3);
        // R3: real-style loads ignore level and table bits
        tag = "R3";
        cpl_i = 3;
        load(1, 16'h1234);
        access(1, 32'h10); access(1, 32'hFFFF); access(1, 32'h1_0000);
        load(2, 16'hFFFF);
        access(2, 32'h0); access(2, 32'hFFFF);
        // R8: mode change keeps the cached image
        tag = "R8";
        @(negedge clk);
        prot_mode_i = 1;
        @(negedge clk);
        access(1, 32'h20); access(2, 32'hFFFE); access(1, 32'h1_0000);
        // R6: privilege decisions
        tag = "R6";
        cpl_i = 0; load(0, 16'h0008);          // idx1 dpl3 ok
        access(0, 32'hFFFF_0000);
        cpl_i = 3; load(3, 16'h0000);          // idx0 dpl0, cpl3: fault
        access(3, 32'h0);
        cpl_i = 0; load(3, 16'h0003);          // rpl3 > dpl0: fault
        access(3, 32'h0);
        cpl_i = 2; load(3, 16'h0019);          // idx3 dpl2, max=2: ok
        access(3, 32'h3FFF); access(3, 32'h4000);
        cpl_i = 2; load(2, 16'h001B);          // rpl3 > dpl2: fault
        access(2, 32'h5);
        cpl_i = 1; load(2, 16'h0011);          // idx2 dpl1 equal: ok
        access(2, 32'h100); access(2, 32'h101);
        // R4: table indicator bit set
        tag = "R4";
        cpl_i = 0; load(0, 16'h000C);
        access(0, 32'h1);
        // R5: index bounds
        tag = "R5";
        load(1, 16'h0040); access(1, 32'h0);   // idx8 fault
        load(1, 16'hFFF8); access(1, 32'h0);   // idx 8191 fault
        load(1, 16'h0038); access(1, 32'h7FF); access(1, 32'h800); // idx7 ok
        // R7: faults leave every register unchanged
        tag = "R7";
        cpl_i = 3; load(1, 16'h0010);          // idx2 dpl1 fault
        for (int s = 0; s < NSEG; s++) access(s, 32'h4);
        // R2: requests while busy are ignored
        tag = "R2";
        cpl_i = 0;
        ld_valid_i = 1; ld_seg_i = 0; ld_sel_i = 16'h0018;
        @(negedge clk);
        ld_sel_i = 16'h0000; ld_seg_i = 1;
        @(negedge clk);
        ld_valid_i = 0;
        repeat (3) @(negedge clk);
        access(0, 32'h10); access(1, 32'h10);
        // R9: mixed random traffic
        tag = "R9";
        for (int n = 0; n < 600; n++) begin
            int s;
            s = $urandom_range(0, NSEG - 1);
            acc_valid_i = ($urandom_range(0, 3) != 0);
            acc_seg_i = 2'(s);
            case ($urandom_range(0, 3))
                0: acc_off_i = m_lim[s];
                1: acc_off_i = m_lim[s] + 1;
                2: acc_off_i = m_lim[s] - 1;
                default: acc_off_i = $urandom();
            endcase
            ld_valid_i = ($urandom_range(0, 2) == 0);
            ld_seg_i = 2'($urandom_range(0, NSEG - 1));
            ld_sel_i = {13'($urandom_range(0, 9)), ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3))};
            cpl_i = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) prot_mode_i = ~prot_mode_i;
            @(negedge clk);
        end
        acc_valid_i = 0; ld_valid_i = 0;
        repeat (4) @(negedge clk);
        running = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule